// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This unit performs one arithmetic or logic operation per clock on two operands that are both either 8 bits or 16 bits wide, as chosen by a single size input. It supports plain addition, addition with an incoming carry, subtraction used as a comparison, bitwise AND, sign extension of a byte into a word, and three operations that only act on the carry flag: clear, set and invert.

Along with the result it produces a write-enable for the result and six status flags: carry, parity, auxiliary carry, zero, sign and overflow. Each flag has its own update bit, so the surrounding datapath knows which flags to commit. The outputs are registered. A result and its flags appear on the clock edge after the inputs are presented. Operand fetch, register storage and addressing belong to the surrounding datapath.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 (ADD) returns operand A plus operand B at the selected width, ignores carry_in, and asserts result_we with all six flag update bits set.
- R2: Opcode 1 (ADC) returns A + B + carry_in at the selected width, asserts result_we, and sets all six flag update bits. For example, 5 + 1 with carry_in = 1 gives 7.
- R3: For ADD, ADC and CMP, carry is the carry (or, for CMP, the borrow) out of the top bit of the selected width. Auxiliary is the carry or borrow out of bit 3.
- R4: For ADD, ADC and CMP, overflow is 1 exactly when the signed result at the selected width does not fit. For addition this means the operands have equal signs and the result sign differs. For CMP it means the operands have different signs and the result sign differs from A's.
- R5: Opcode 2 (CMP) puts A − B on result, keeps result_we low, and sets all six flag update bits. Equal operands give zero = 1.
- R6: Opcode 3 (AND) returns A AND B, asserts result_we, and forces carry and overflow to 0. Zero, sign and parity come from the result. The auxiliary update bit is 0.
- R7: Zero and sign are taken at the selected width. Parity is 1 when the low 8 result bits hold an even number of ones, in both sizes.
- R8: Opcode 4 (CBW) returns a word whose low byte is A[7:0] and whose high byte is FFh when A[7] = 1 and 00h otherwise, whatever the size input is. It asserts result_we and sets no flag update bit.
- R9: Opcodes 5 (CLC), 6 (STC) and 7 (CMC) set carry to 0, to 1, and to the inverse of carry_in respectively. Only the carry update bit is set, result_we is low, and result equals A.
- R10: When word_sel = 0 (byte size), result[15:8] equals A[15:8] for every opcode except CBW.
- R11: Outputs register the inputs present at a rising clock edge. While rst_n is low, all outputs are 0.
- R12: Flag bit positions in flags and flag_mask are: 0 carry, 1 parity, 2 auxiliary, 3 zero, 4 sign, 5 overflow. A flag whose update bit is 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 3 | Operation select, encoded as in R1, R2, R5, R6, R8, R9 |
| word_sel | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Registered result |
| result_we | output | 1 | Result should be written back |
| flags | output | 6 | Status flag values |
| flag_mask | output | 6 | Per-flag update enables |

## Verification
Every output comes from one register stage, so a stimulus applied before a rising edge has its result, write-enable and flags due on that edge. The bench changes inputs only on falling edges. It samples outputs on the next falling edge, half a cycle after the register loads, and each vector occupies exactly one cycle. The in-design properties follow the same one-cycle relation: they compare the registered outputs with the inputs seen one edge earlier, and they are enabled only once a post-reset load has taken place.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_CMP = 3'd2,
        OP_AND = 3'd3,
        OP_CBW = 3'd4,
        OP_CLC = 3'd5,
        OP_STC = 3'd6,
        OP_CMC = 3'd7
    } alu_op_e;

    // bit 0 carry ... bit 5 overflow
    typedef struct packed {
        logic ov;
        logic sg;
        logic zr;
        logic ax;
        logic pr;
        logic cy;
    } flag_t;

    localparam int FLAG_N = 6;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 16,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    input  logic              word,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              aux,
    output logic              ovf
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic              c0;
    logic [DATA_W:0]   full_w;
    logic [HALF_W:0]   full_b;
    logic              raw_c;
    logic              top_a, top_b, top_r;
    logic [DATA_W-1:0] mix;

    always_comb begin
        b_eff  = sub ? ~b : b;
        c0     = sub ? 1'b1 : cin;
        full_w = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c0};
        full_b = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
               + {{HALF_W{1'b0}}, c0};
        if (word) begin
            res   = full_w[DATA_W-1:0];
            raw_c = full_w[DATA_W];
            top_a = a[DATA_W-1];
            top_b = b_eff[DATA_W-1];
            top_r = full_w[DATA_W-1];
        end else begin
            res   = {a[DATA_W-1:HALF_W], full_b[HALF_W-1:0]};
            raw_c = full_b[HALF_W];
            top_a = a[HALF_W-1];
            top_b = b_eff[HALF_W-1];
            top_r = full_b[HALF_W-1];
        end
        // borrow is the inverse of the adder carry when subtracting
        cout = raw_c ^ sub;
        mix  = a ^ b_eff ^ res;
        aux  = mix[NIB_W] ^ sub;
        ovf  = (top_a == top_b) && (top_r != top_a);
    end

endmodule

// File: rtl/alu_status.sv
module alu_status #(
    parameter int DATA_W = 16,
    parameter int PAR_W  = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              word,
    output logic              zf,
    output logic              sf,
    output logic              pf
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        zf = word ? (res == '0) : (res[HALF_W-1:0] == '0);
        sf = word ? res[DATA_W-1] : res[HALF_W-1];
        pf = ~^res[PAR_W-1:0];
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              word,
    output logic [DATA_W-1:0] and_res,
    output logic [DATA_W-1:0] ext_res
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] conj;

    always_comb begin
        conj    = a & b;
        and_res = word ? conj : {a[DATA_W-1:HALF_W], conj[HALF_W-1:0]};
        ext_res = {{HALF_W{a[HALF_W-1]}}, a[HALF_W-1:0]};
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PAR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        opcode,
    input  logic              word_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic [FLAG_N-1:0] flags,
    output logic [FLAG_N-1:0] flag_mask
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        flag_t             fl;
        flag_t             mk;
    } alu_state_t;

    alu_state_t st_d, st_q;
    alu_op_e    op;

    logic [DATA_W-1:0] as_res, and_res, ext_res, stat_in;
    logic              as_cout, as_aux, as_ovf, as_cin, as_sub;
    logic              zf, sf, pf;

    assign op     = alu_op_e'(opcode);
    assign as_sub = (op == OP_CMP);
    assign as_cin = (op == OP_ADC) ? carry_in : 1'b0;

    alu_addsub #(.DATA_W(DATA_W), .NIB_W(4)) u_addsub (
        .a(opnd_a), .b(opnd_b), .cin(as_cin), .sub(as_sub), .word(word_sel),
        .res(as_res), .cout(as_cout), .aux(as_aux), .ovf(as_ovf)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a(opnd_a), .b(opnd_b), .word(word_sel),
        .and_res(and_res), .ext_res(ext_res)
    );

    assign stat_in = (op == OP_AND) ? and_res : as_res;

    alu_status #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_status (
        .res(stat_in), .word(word_sel), .zf(zf), .sf(sf), .pf(pf)
    );

    always_comb begin
        st_d     = '0;
        st_d.res = opnd_a;
        case (op)
            OP_ADD, OP_ADC, OP_CMP: begin
                st_d.res = as_res;
                st_d.we  = (op != OP_CMP);
                st_d.fl  = '{ov: as_ovf, sg: sf, zr: zf, ax: as_aux, pr: pf, cy: as_cout};
                st_d.mk  = '1;
            end
            OP_AND: begin
                st_d.res = and_res;
                st_d.we  = 1'b1;
                st_d.fl  = '{ov: 1'b0, sg: sf, zr: zf, ax: 1'b0, pr: pf, cy: 1'b0};
                st_d.mk  = '{ov: 1'b1, sg: 1'b1, zr: 1'b1, ax: 1'b0, pr: 1'b1, cy: 1'b1};
            end
            OP_CBW: begin
                st_d.res = ext_res;
                st_d.we  = 1'b1;
            end
            OP_CLC, OP_STC, OP_CMC: begin
                st_d.mk.cy = 1'b1;
                st_d.fl.cy = (op == OP_STC) ? 1'b1 :
                             (op == OP_CMC) ? ~carry_in : 1'b0;
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result    = st_q.res;
    assign result_we = st_q.we;
    assign flags     = st_q.fl;
    assign flag_mask = st_q.mk;

    // marks that the output register holds a post-reset load
    logic primed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(opcode) == 3'd2) |-> (!result_we && flag_mask == 6'h3F));

    a_r6_and_cy_ov_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(opcode) == 3'd3) |-> (!flags[0] && !flags[5] && !flag_mask[2]));

    a_r8_cbw_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(opcode) == 3'd4) |->
        (flag_mask == '0 && result[HALF_W-1:0] == $past(opnd_a[HALF_W-1:0])));

    a_r9_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(opcode) >= 3'd5) |->
        (flag_mask == 6'b000001 && !result_we && result == $past(opnd_a)));

    a_r10_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !$past(word_sel) && $past(opcode) != 3'd4) |->
        (result[DATA_W-1:HALF_W] == $past(opnd_a[DATA_W-1:HALF_W])));

    a_r12_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> ((flags & ~flag_mask) == '0));

endmodule

// File: tb/sim_flag_alu.sv
module sim_flag_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  opcode = '0;
    logic        word_sel = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic        result_we;
    logic [5:0]  flags, flag_mask;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    flag_alu u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .word_sel(word_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .result(result), .result_we(result_we), .flags(flags), .flag_mask(flag_mask)
    );

    // expected {result, we, flags, mask} from the requirements
    function automatic logic [28:0] model(input logic [2:0] op, input logic w,
                                          input logic [15:0] a, input logic [15:0] b,
                                          input logic ci);
        logic [15:0] m, r, res;
        logic [31:0] full;
        int          msb, width;
        logic        cy, ax, ov, we;
        logic [5:0]  fl, mk;
        m     = w ? 16'hFFFF : 16'h00FF;
        msb   = w ? 15 : 7;
        width = w ? 16 : 8;
        r = 16'h0; cy = 0; ax = 0; ov = 0; we = 0; fl = '0; mk = '0; res = a;
        case (op)
            3'd0, 3'd1: begin
                logic c;
                c    = (op == 3'd1) ? ci : 1'b0;
                full = 32'(a & m) + 32'(b & m) + 32'(c);
                r    = full[15:0] & m;
                cy   = full[width];
                ax   = (32'(a[3:0]) + 32'(b[3:0]) + 32'(c)) > 15;
                ov   = (a[msb] == b[msb]) && (r[msb] != a[msb]);
                we   = 1; mk = 6'h3F;
            end
            3'd2: begin
                r  = (a - b) & m;
                cy = (a & m) < (b & m);
                ax = a[3:0] < b[3:0];
                ov = (a[msb] != b[msb]) && (r[msb] != a[msb]);
                we = 0; mk = 6'h3F;
            end
            3'd3: begin
                r = a & b & m; we = 1; mk = 6'b111011;
            end
            default: ;
        endcase
        if (op <= 3'd3) begin
            res = w ? r : {a[15:8], r[7:0]};
            fl  = {ov, r[msb], (r == 16'h0), ax, ~^r[7:0], cy} & mk;
        end else if (op == 3'd4) begin
            res = {{8{a[7]}}, a[7:0]};
            we  = 1;
        end else begin
            mk  = 6'b000001;
            fl  = {5'b0, (op == 3'd6) ? 1'b1 : (op == 3'd7) ? ~ci : 1'b0};
        end
        return {res, we, fl, mk};
    endfunction

    task automatic apply(input logic [2:0] op, input logic w, input logic [15:0] a,
                         input logic [15:0] b, input logic ci, input string tag);
        logic [28:0] exp, got;
        opcode = op; word_sel = w; opnd_a = a; opnd_b = b; carry_in = ci;
        exp = model(op, w, a, b, ci);
        @(posedge clk);
        @(negedge clk);
        got = {result, result_we, flags, flag_mask};
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d w=%0b a=%h b=%h ci=%0b: got res=%h we=%0b fl=%b mk=%b, expected res=%h we=%0b fl=%b mk=%b",
                     tag, op, w, a, b, ci, got[28:13], got[12], got[11:6], got[5:0],
                     exp[28:13], exp[12], exp[11:6], exp[5:0]);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R8";
            default: return "R9";
        endcase
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++;
                $display("FAIL watchdog: run did not finish");
                $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        n_vec++;
        if ({result, result_we, flags, flag_mask} !== 29'h0) begin
            n_bad++;
            $display("FAIL R11 reset: got %h expected 0", {result, result_we, flags, flag_mask});
        end
        rst_n = 1'b1;

        apply(3'd1, 0, 16'h0005, 16'h0001, 1, "R2");      // 5+1+1 = 7
        apply(3'd0, 0, 16'h0005, 16'h0001, 1, "R1");      // carry_in ignored
        apply(3'd0, 0, 16'h000F, 16'h0001, 0, "R3");      // aux from bit 3
        apply(3'd0, 1, 16'hFFFF, 16'h0001, 0, "R3");      // word carry out, zero
        apply(3'd0, 0, 16'h127F, 16'h0001, 0, "R4");      // byte signed overflow
        apply(3'd0, 1, 16'h7FFF, 16'h0001, 0, "R4");      // word signed overflow
        apply(3'd2, 1, 16'h8000, 16'h0001, 0, "R4");      // compare overflow
        apply(3'd2, 0, 16'hAB05, 16'hCD05, 0, "R5");      // equal bytes -> zero
        apply(3'd2, 0, 16'h0010, 16'h0001, 0, "R3");      // aux borrow
        apply(3'd2, 1, 16'h0001, 16'h0002, 0, "R3");      // borrow out of top
        apply(3'd3, 0, 16'hFF61, 16'h00DF, 1, "R6");      // AND byte
        apply(3'd0, 1, 16'h0100, 16'h0000, 0, "R7");      // parity on low byte only
        apply(3'd0, 0, 16'h0080, 16'h0000, 0, "R7");      // byte sign
        apply(3'd4, 0, 16'h00FB, 16'h1234, 1, "R8");      // FFFB
        apply(3'd4, 1, 16'hAA7B, 16'h0000, 0, "R8");      // 007B
        apply(3'd5, 1, 16'h1234, 16'h5678, 1, "R9");
        apply(3'd6, 0, 16'h4321, 16'h0000, 0, "R9");
        apply(3'd7, 1, 16'h0F0F, 16'h0000, 1, "R9");
        apply(3'd7, 1, 16'h0F0F, 16'h0000, 0, "R9");
        apply(3'd3, 0, 16'h5A00, 16'h0000, 0, "R10");     // upper byte from A
        apply(3'd2, 1, 16'h0000, 16'h0000, 1, "R12");     // masked flags zero

        for (int i = 0; i < 3000; i++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            apply(op, 1'($urandom), 16'($urandom), 16'($urandom), 1'($urandom), tag_of(op));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule